// File: doc/BRIEF.md
# Serial Register-Bank Slave with Two-Frame Readback

This block is a serial-bus slave that lets an external master program and inspect a bank of eight register rows. Every access is one 32-bit word, sent most-significant bit first while chip-select is low. The three least-significant bits of the word pick the row, and the upper 29 bits are the payload stored in that row. A word is committed only when chip-select is released after exactly 32 rising SCLK edges. Any other release throws the word away.

Readback takes two frames. The master first writes a read request into the instruction row, naming the row it wants. During the next chip-select frame the slave shifts out that row, together with its address, on a multiplexed output pin. A field in row 2 decides whether the pin carries serial data at all. A bit in row 0 picks whether each output bit is launched on a falling or a rising SCLK edge.

SCLK, chip-select and MOSI are synchronised into a fast system clock, and edges are detected in that clock domain. The row contents are brought out as one flat vector so that the logic beside the block can use them directly.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset every row is zero except row 0, whose payload bit 0 (word bit 3, the edge-select bit) is 1. The output pin is low.
- R2: While chip-select is low, each rising SCLK edge shifts in one MOSI bit, MSB first. On a commit, word bits [2:0] select the row and word bits [31:3] become that row's 29-bit payload.
- R3: A release of chip-select after fewer than 32 or more than 32 rising edges (including zero) changes no row.
- R4: A committed write reaches the row outputs (row r at rows_o[r*29 +: 29]) and changes no other row.
- R5: A committed write to row 7 with word bit 3 = 1 requests a read of the row given by word bits [6:4]. With word bit 3 = 0, no read is requested.
- R6: The frame after a read request shifts out 32 bits, MSB first: the row payload in bits [31:3] and the row address in bits [2:0]. Bits after the 32nd are 0. The request is consumed by that one frame even if the frame is cut short, and later frames shift out zeros.
- R7: The output pin carries serial data only while row 2 word bits [28:26] (payload bits [25:23]) equal 3'b111. Otherwise it stays 0.
- R8: With edge-select = 1, the first bit appears at the fall of chip-select and each later bit follows a falling SCLK edge. With edge-select = 0, the pin is 0 until the first rising SCLK edge and each bit follows a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip-select |
| spi_mosi | input | 1 | Serial data from the master |
| mux_pin | output | 1 | Multiplexed pin; carries serial read data when enabled |
| rows_o | output | 232 | Payloads of the eight rows, row r at [r*29 +: 29] |

## Verification
The assertions check the following on every cycle:
- the frame bit counter stays within its saturation limit and is zero while chip-select is idle;
- a commit lands in exactly the addressed row;
- a read request is latched at the end of its frame and is dropped at the end of the next one;
- the pin is zero whenever the routing field is not 3'b111;
- the output shifter is silent outside a frame and holds low until the first rising edge in rising-edge mode.

Only the bench's scenarios can show the following:
- the serial bit order and the content of each readback word in both launch modes;
- that frames of 0, 31 or 33 bits leave the rows untouched;
- that an interrupted read still consumes its request.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
   // Which SCLK edge launches the next serial output bit.
   typedef enum logic {
      LAUNCH_RISE = 1'b0,
      LAUNCH_FALL = 1'b1
   } launch_e;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rb_rx.sv
module spi_rb_rx #(
   parameter int WORD_W = 32,
   parameter int ADDR_W = 3,
   localparam int DATA_W = WORD_W - ADDR_W,
   localparam int CNT_W  = $clog2(WORD_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              cs_rise,
   input  logic              sclk_rise,
   input  logic              mosi,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (cs_rise) begin
         cnt <= '0;
      end else if (cs_act && sclk_rise) begin
         shreg <= {shreg[WORD_W-2:0], mosi};
         if (cnt != OVER) cnt <= cnt + 1'b1;
      end
   end

   // Commit only on a release that follows exactly a full word.
   assign wr_en   = cs_rise && (cnt == FULL);
   assign wr_addr = shreg[ADDR_W-1:0];
   assign wr_data = shreg[WORD_W-1:ADDR_W];

   a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= OVER);
   a_r2_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_act && !cs_rise) |-> (cnt == '0));
endmodule

// File: rtl/spi_rb_bank.sv
module spi_rb_bank #(
   parameter int          WORD_W       = 32,
   parameter int          ADDR_W       = 3,
   parameter int          INSTR_ROW    = 7,
   parameter int          RD_FLAG_BIT  = 0,
   parameter int          RD_ADDR_LSB  = 1,
   parameter int          EDGE_ROW     = 0,
   parameter int          EDGE_BIT     = 0,
   parameter int          MUX_ROW      = 2,
   parameter int          MUX_LSB      = 23,
   parameter int          MUX_W        = 3,
   parameter logic [MUX_W-1:0] MUX_SDO_CODE = '1,
   localparam int DATA_W = WORD_W - ADDR_W,
   localparam int NROWS  = 1 << ADDR_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic                    frame_end,
   output logic [NROWS*DATA_W-1:0] rows_flat,
   output logic                    rd_pend,
   output logic [WORD_W-1:0]       rd_word,
   output logic                    edge_sel,
   output logic                    sdo_sel
);
   logic [DATA_W-1:0] row_q [NROWS];
   logic [ADDR_W-1:0] rd_addr;
   logic              req_now;

   generate
      for (genvar r = 0; r < NROWS; r++) begin : g_row
         localparam logic [DATA_W-1:0] RST_ROW =
            (r == EDGE_ROW) ? (DATA_W'(1) << EDGE_BIT) : '0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               row_q[r] <= RST_ROW;
            else if (wr_en && (wr_addr == ADDR_W'(r)))
               row_q[r] <= wr_data;
         end
         assign rows_flat[r*DATA_W +: DATA_W] = row_q[r];
      end
   endgenerate

   assign req_now = wr_en && (wr_addr == ADDR_W'(INSTR_ROW)) && wr_data[RD_FLAG_BIT];

   // A request lives for exactly one later frame.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
         rd_addr <= '0;
      end else if (frame_end) begin
         rd_pend <= req_now;
         if (req_now) rd_addr <= wr_data[RD_ADDR_LSB +: ADDR_W];
      end
   end

   assign rd_word  = {row_q[rd_addr], rd_addr};
   assign edge_sel = row_q[EDGE_ROW][EDGE_BIT];
   assign sdo_sel  = (row_q[MUX_ROW][MUX_LSB +: MUX_W] == MUX_SDO_CODE);

   a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (row_q[$past(wr_addr)] == $past(wr_data)));
   a_r5_request_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && req_now) |=> rd_pend);
   a_r6_request_single_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !req_now) |=> !rd_pend);
endmodule

// File: rtl/spi_rb_tx.sv
module spi_rb_tx
   import spi_rb_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              cs_fall,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              rd_pend,
   input  logic [WORD_W-1:0] rd_word,
   input  logic              edge_sel,
   output logic              sdo
);
   logic [WORD_W-1:0] shreg;
   launch_e           mode_q;
   logic              launch;

   assign launch = (mode_q == LAUNCH_FALL) ? sclk_fall : sclk_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         sdo    <= 1'b0;
         mode_q <= LAUNCH_FALL;
      end else if (cs_fall) begin
         mode_q <= launch_e'(edge_sel);
         if (!rd_pend) begin
            shreg <= '0;
            sdo   <= 1'b0;
         end else if (edge_sel) begin
            sdo   <= rd_word[WORD_W-1];
            shreg <= {rd_word[WORD_W-2:0], 1'b0};
         end else begin
            sdo   <= 1'b0;
            shreg <= rd_word;
         end
      end else if (!cs_act) begin
         shreg <= '0;
         sdo   <= 1'b0;
      end else if (launch) begin
         sdo   <= shreg[WORD_W-1];
         shreg <= {shreg[WORD_W-2:0], 1'b0};
      end
   end

   a_r6_quiet_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !sdo);
   a_r8_rise_mode_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_fall && !edge_sel) |=> !sdo);
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave #(
   parameter int WORD_W      = 32,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int INSTR_ROW   = 7,
   parameter int RD_FLAG_BIT = 0,
   parameter int RD_ADDR_LSB = 1,
   parameter int EDGE_ROW    = 0,
   parameter int EDGE_BIT    = 0,
   parameter int MUX_ROW     = 2,
   parameter int MUX_LSB     = 23,
   parameter int MUX_W       = 3,
   localparam int DATA_W = WORD_W - ADDR_W,
   localparam int NROWS  = 1 << ADDR_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    spi_sclk,
   input  logic                    spi_cs_n,
   input  logic                    spi_mosi,
   output logic                    mux_pin,
   output logic [NROWS*DATA_W-1:0] rows_o
);
   generate
      if (SYNC_STAGES < 2)
         $error("SYNC_STAGES must be at least 2");
      if (WORD_W < 8 || ADDR_W < 1 || ADDR_W >= WORD_W)
         $error("word and address widths out of range");
      if (RD_ADDR_LSB + ADDR_W > DATA_W || RD_FLAG_BIT >= DATA_W)
         $error("read instruction fields exceed the payload");
      if (MUX_LSB + MUX_W > DATA_W || EDGE_BIT >= DATA_W)
         $error("control fields exceed the payload");
      if (INSTR_ROW >= NROWS || EDGE_ROW >= NROWS || MUX_ROW >= NROWS)
         $error("control rows outside the bank");
   endgenerate

   logic [2:0] s_in;
   logic       s_sclk, s_cs_n, s_mosi;
   logic       sclk_q, cs_q;
   logic       sclk_rise, sclk_fall, cs_rise, cs_fall, cs_act;

   spi_rb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({spi_mosi, spi_cs_n, spi_sclk}), .q(s_in));

   assign {s_mosi, s_cs_n, s_sclk} = s_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cs_q   <= 1'b1;
      end else begin
         sclk_q <= s_sclk;
         cs_q   <= s_cs_n;
      end
   end

   assign sclk_rise = s_sclk & ~sclk_q;
   assign sclk_fall = ~s_sclk & sclk_q;
   assign cs_rise   = s_cs_n & ~cs_q;
   assign cs_fall   = ~s_cs_n & cs_q;
   assign cs_act    = ~s_cs_n;

   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              rd_pend, edge_sel, sdo_sel, sdo;
   logic [WORD_W-1:0] rd_word;

   spi_rb_rx #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_rise(cs_rise),
      .sclk_rise(sclk_rise), .mosi(s_mosi),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

   spi_rb_bank #(
      .WORD_W(WORD_W), .ADDR_W(ADDR_W), .INSTR_ROW(INSTR_ROW),
      .RD_FLAG_BIT(RD_FLAG_BIT), .RD_ADDR_LSB(RD_ADDR_LSB),
      .EDGE_ROW(EDGE_ROW), .EDGE_BIT(EDGE_BIT),
      .MUX_ROW(MUX_ROW), .MUX_LSB(MUX_LSB), .MUX_W(MUX_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_end(cs_rise), .rows_flat(rows_o),
      .rd_pend(rd_pend), .rd_word(rd_word), .edge_sel(edge_sel),
      .sdo_sel(sdo_sel));

   spi_rb_tx #(.WORD_W(WORD_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall),
      .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .rd_pend(rd_pend),
      .rd_word(rd_word), .edge_sel(edge_sel), .sdo(sdo));

   assign mux_pin = sdo_sel ? sdo : 1'b0;

   a_r7_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_sel |-> !mux_pin);
endmodule

// File: tb/spi_regbank_slave_bench.sv
module spi_regbank_slave_bench;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sclk = 1'b0;
   logic spi_cs_n = 1'b1;
   logic spi_mosi = 1'b0;
   logic mux_pin;
   logic [8*29-1:0] rows_o;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   bit mode_fall = 1'b1;
   logic [28:0] mrow [8];

   always #5 clk = ~clk;

   spi_regbank_slave u_spi_regbank_slave (
      .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .mux_pin(mux_pin), .rows_o(rows_o));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame(input logic [31:0] w, input int nbits,
                        output logic [31:0] rd, output logic extra, output logic pre);
      rd = '0; extra = 1'b0; pre = 1'b0;
      spi_cs_n = 1'b0;
      waitc(HALF);
      for (int i = 0; i < nbits; i++) begin
         spi_mosi = (i < 32) ? w[31-i] : 1'b0;
         waitc(HALF);
         if (i == 0) pre = mux_pin;
         if (mode_fall) begin
            if (i < 32) rd[31-i] = mux_pin; else extra |= mux_pin;
         end
         spi_sclk = 1'b1;
         waitc(HALF);
         if (!mode_fall) begin
            if (i < 32) rd[31-i] = mux_pin; else extra |= mux_pin;
         end
         spi_sclk = 1'b0;
      end
      waitc(HALF);
      spi_cs_n = 1'b1;
      waitc(3*HALF);
   endtask

   task automatic wr(input int row, input logic [28:0] data);
      logic [31:0] rd;
      logic ex, pr;
      frame({data, 3'(row)}, 32, rd, ex, pr);
      mrow[row] = data;
   endtask

   task automatic check_rows(input string tag);
      for (int r = 0; r < 8; r++)
         check(tag, 32'(rows_o[r*29 +: 29]), 32'(mrow[r]));
   endtask

   function automatic logic [28:0] pat(input int r);
      return 29'((32'h0ABC_DEF5 ^ (32'h0135_7913 * (r + 1))) & 32'h1FFF_FFFF);
   endfunction

   initial begin
      logic [31:0] rd, expw;
      logic ex, pr;
      for (int r = 0; r < 8; r++) mrow[r] = '0;
      mrow[0] = 29'd1;
      waitc(4);
      rst_n = 1'b1;
      waitc(4);
      // R1 reset state
      check_rows("R1 reset rows");
      check("R1 pin low", 32'(mux_pin), 32'd0);

      // R7: read with routing field off gives nothing on the pin
      wr(1, pat(1));
      wr(7, 29'((1 << 1) | 1));
      frame({mrow[6], 3'd6}, 32, rd, ex, pr);
      check("R7 pin gated off", rd, 32'd0);

      // R2/R4: fill rows, enabling the routing field in row 2
      wr(2, pat(2) | (29'd7 << 23));
      for (int r = 3; r < 7; r++) begin
         wr(r, pat(r));
         check_rows("R2 R4 write rows");
      end

      // R3: framing errors
      frame({~pat(3), 3'd3}, 31, rd, ex, pr);
      check_rows("R3 31-bit frame");
      frame({~pat(4), 3'd4}, 33, rd, ex, pr);
      check_rows("R3 33-bit frame");
      frame({~pat(5), 3'd5}, 0, rd, ex, pr);
      check_rows("R3 empty frame");

      // R6/R8: read every row in both launch modes
      for (int m = 1; m >= 0; m--) begin
         wr(0, (pat(0) & ~29'd1) | 29'(m));
         mode_fall = (m == 1);
         for (int r = 0; r < 8; r++) begin
            wr(7, 29'((r << 1) | 1));
            expw = {mrow[r], 3'(r)};
            frame({mrow[6], 3'd6}, 32, rd, ex, pr);
            check("R6 R8 readback word", rd, expw);
            check("R8 first-bit launch", 32'(pr), mode_fall ? 32'(expw[31]) : 32'd0);
         end
      end

      // R6: bits past 32 are zero; request then consumed
      wr(7, 29'((5 << 1) | 1));
      frame(32'hFFFF_FFFF, 33, rd, ex, pr);
      check("R6 33-clock read word", rd, {mrow[5], 3'd5});
      check("R6 extra bit zero", 32'(ex), 32'd0);
      frame({mrow[6], 3'd6}, 32, rd, ex, pr);
      check("R6 request consumed", rd, 32'd0);

      // R6: interrupted read still consumes the request
      wr(7, 29'((3 << 1) | 1));
      frame({mrow[6], 3'd6}, 10, rd, ex, pr);
      check("R6 partial read bits", rd >> 22, 32'({mrow[3], 3'd3}) >> 22);
      frame({mrow[6], 3'd6}, 32, rd, ex, pr);
      check("R6 after cut read", rd, 32'd0);

      // R5: row 7 write without the read flag
      wr(7, 29'(4 << 1));
      frame({mrow[6], 3'd6}, 32, rd, ex, pr);
      check("R5 no read flag", rd, 32'd0);
      check_rows("R5 row7 stored");

      // R7: routing field changed away from 3'b111
      wr(2, pat(2) & ~(29'd1 << 24));
      wr(7, 29'((3 << 1) | 1));
      frame({mrow[6], 3'd6}, 32, rd, ex, pr);
      check("R7 pin gated again", rd, 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule